// File: doc/BRIEF.md
# PUF Response Stability Characterizer

This block measures how stable a delay-based physical unclonable function is for one challenge. It holds a 64-bit challenge on the PUF core. It then asks the core for a response again and again, using an enable/ready handshake, until a programmed number of repetitions has been collected. Every response bit goes into a count of ones or a count of zeros. The block also notes whether any response differs from the first one of the run, which marks the challenge as metastable.

After the last repetition, one shared restoring divider runs twice. The first pass gives the fraction of ones as an unsigned 1.16 fixed-point value. The second pass gives the signed bias, ones minus zeros over the total, in the same scale. A multiplier then turns the fraction into the per-bit noise estimate 2·f·(1−f). A one-cycle done pulse marks all results as valid. The results stay in place until the next run starts. The PUF core is outside the block. The host side is a start strobe, a challenge and a repetition count.

Top module: `puf_stab_char`

## Requirements
- R1: `pufEnable` is high only while a run is waiting for a response. A response bit is taken in each cycle where `pufEnable` and `pufReady` are both high, and each such cycle is one repetition. If enable is still high after a ready pulse, it counts as a new request.
- R2: A start with a non-zero count latches `cfgChallenge` and `cfgReps` and clears the counts, the flag and the results. Changes to `cfgChallenge` or `cfgReps` during a run have no effect, and `pufChallenge` stays at the latched value.
- R3: A start request while `busy` is high is ignored. A start with `cfgReps` equal to 0 is ignored, and `busy` stays low.
- R4: `onesCount` and `zerosCount` count the captured 1 and 0 responses. At done, their sum equals the latched repetition count.
- R5: `metastable` is 1 at done exactly when some captured response differs from the first response of the run.
- R6: `fracOnes` = floor(ones·65536 / reps), unsigned with 16 fractional bits. 65536 means all ones and 0 means all zeros.
- R7: `biasOut` is an 18-bit two's complement value equal to ±floor(|ones−zeros|·65536 / reps). It is negative when zeros outnumber ones.
- R8: `noiseOut` = floor(2·fracOnes·(65536−fracOnes) / 65536). Its value never exceeds 32768.
- R9: `done` is high for exactly one cycle. `busy` falls on the following cycle. All results hold their values until the next accepted start.
- R10: After reset, `busy`, `done`, `pufEnable`, both counts, the flag and all three results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe from the host |
| cfgChallenge | input | 64 | Challenge to characterize |
| cfgReps | input | 17 | Number of repetitions, 1 or more |
| busy | output | 1 | Run or computation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| onesCount | output | 17 | Responses equal to 1 |
| zerosCount | output | 17 | Responses equal to 0 |
| metastable | output | 1 | Response flipped during the run |
| fracOnes | output | 17 | Fraction of ones, 1.16 unsigned |
| biasOut | output | 18 | Signed bias, 16 fractional bits |
| noiseOut | output | 17 | Noise estimate 2f(1−f), 0.16 |
| pufChallenge | output | 64 | Challenge applied to the PUF core |
| pufEnable | output | 1 | Response request to the PUF core |
| pufReady | input | 1 | Response valid pulse from the core |
| pufResponse | input | 1 | Response bit from the core |

## Verification
The case that matters most is a new start request that lands on the same clock edge as a response capture. In that cycle the repetition counter is moving forward, and a faulty start decode could reload the count or the challenge. The bench waits until `pufReady` is high and then raises `startReq` with a different challenge and count, so that both are sampled on the capture edge. It judges the result by the challenge presented for the rest of the run, the final ones and zeros, and whether the response model runs out of queued bits.

// File: rtl/puf_stab_pkg.sv
package puf_stab_pkg;

  typedef struct packed {
    logic clearRun;   // accepted start: latch config, clear counts
    logic capture;    // response bit valid this cycle
    logic firstCap;   // capture is the first of the run
    logic divLoad;    // load divider with dividend selected by divSel
    logic divSel;     // 0: ones, 1: |ones - zeros|
    logic divStep;    // one restoring iteration
    logic storeFrac;  // divider holds the fraction quotient
    logic storeBias;  // divider holds the bias magnitude quotient
  } ctrl_strobe_t;

endpackage

// File: rtl/puf_stab_ctrl.sv
module puf_stab_ctrl
  import puf_stab_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int DIV_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [CNT_W-1:0] cfgReps,
  input  logic             pufReady,
  output logic             pufEnable,
  output logic             busy,
  output logic             done,
  output ctrl_strobe_t     strobe
);

  localparam int IT_W = $clog2(DIV_W + 1);
  localparam logic [IT_W-1:0] IT_LAST = IT_W'(DIV_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_DIVF_LD, S_DIVF_RUN, S_DIVB_LD, S_DIVB_RUN, S_FIN, S_DONE
  } state_t;

  state_t           state, stateNxt;
  logic [CNT_W-1:0] repsLat, capCnt;
  logic [IT_W-1:0]  iter;
  logic             lastCap, iterLast, startOk;

  assign lastCap  = (capCnt == repsLat - CNT_W'(1));
  assign iterLast = (iter == IT_LAST);
  assign startOk  = startReq && (cfgReps != '0);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      S_IDLE: if (startOk) begin
        strobe.clearRun = 1'b1;
        stateNxt        = S_REQ;
      end
      S_REQ: if (pufReady) begin
        strobe.capture  = 1'b1;
        strobe.firstCap = (capCnt == '0);
        if (lastCap) stateNxt = S_DIVF_LD;
      end
      S_DIVF_LD: begin
        strobe.divLoad = 1'b1;
        stateNxt       = S_DIVF_RUN;
      end
      S_DIVF_RUN: begin
        strobe.divStep = 1'b1;
        if (iterLast) stateNxt = S_DIVB_LD;
      end
      S_DIVB_LD: begin
        strobe.storeFrac = 1'b1;
        strobe.divLoad   = 1'b1;
        strobe.divSel    = 1'b1;
        stateNxt         = S_DIVB_RUN;
      end
      S_DIVB_RUN: begin
        strobe.divStep = 1'b1;
        if (iterLast) stateNxt = S_FIN;
      end
      S_FIN: begin
        strobe.storeBias = 1'b1;
        stateNxt         = S_DONE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      repsLat <= '0;
      capCnt  <= '0;
      iter    <= '0;
    end else begin
      state <= stateNxt;
      if (strobe.clearRun) repsLat <= cfgReps;
      if (strobe.clearRun)                    capCnt <= '0;
      else if (strobe.capture && !lastCap)    capCnt <= capCnt + CNT_W'(1);
      if (strobe.divLoad)      iter <= '0;
      else if (strobe.divStep) iter <= iter + IT_W'(1);
    end
  end

  assign pufEnable = (state == S_REQ);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

endmodule

// File: rtl/puf_stab_dp.sv
module puf_stab_dp
  import puf_stab_pkg::*;
#(
  parameter int CHAL_W = 64,
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctrl_strobe_t                  strobe,
  input  logic [CHAL_W-1:0]             cfgChallenge,
  input  logic                          pufResponse,
  output logic [CHAL_W-1:0]             pufChallenge,
  output logic [CNT_W-1:0]              onesCount,
  output logic [CNT_W-1:0]              zerosCount,
  output logic                          metastable,
  output logic [FRAC_W:0]               fracOnes,
  output logic signed [FRAC_W+1:0]      biasOut,
  output logic [FRAC_W:0]               noiseOut
);

  localparam int DIV_W  = CNT_W + FRAC_W;
  localparam int RES_W  = FRAC_W + 1;
  localparam int BIAS_W = FRAC_W + 2;
  localparam int PROD_W = 2 * RES_W;
  localparam logic [RES_W-1:0] ONE_FX = RES_W'(1) << FRAC_W;

  logic [CNT_W-1:0]  total, absDiff, rem, remNext;
  logic [DIV_W-1:0]  quot, dividend;
  logic [CNT_W:0]    remShift;
  logic              ge, negBias, firstBit;
  logic [RES_W-1:0]  quotRes, oneMinus, noiseCalc;
  logic [BIAS_W-1:0] mag;
  logic [PROD_W-1:0] prod;

  assign total    = onesCount + zerosCount;
  assign negBias  = zerosCount > onesCount;
  assign absDiff  = negBias ? (zerosCount - onesCount) : (onesCount - zerosCount);
  assign dividend = strobe.divSel ? {absDiff, {FRAC_W{1'b0}}}
                                  : {onesCount, {FRAC_W{1'b0}}};

  // restoring division: one quotient bit per step, MSB first
  assign remShift = {rem, quot[DIV_W-1]};
  assign ge       = remShift >= {1'b0, total};
  assign remNext  = CNT_W'(ge ? (remShift - {1'b0, total}) : remShift);

  assign quotRes   = RES_W'(quot);
  assign mag       = {1'b0, quotRes};
  assign oneMinus  = ONE_FX - fracOnes;
  assign prod      = {{RES_W{1'b0}}, fracOnes} * {{RES_W{1'b0}}, oneMinus};
  assign noiseCalc = RES_W'(prod >> (FRAC_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pufChallenge <= '0;
      onesCount    <= '0;
      zerosCount   <= '0;
      metastable   <= 1'b0;
      firstBit     <= 1'b0;
      rem          <= '0;
      quot         <= '0;
      fracOnes     <= '0;
      biasOut      <= '0;
      noiseOut     <= '0;
    end else begin
      if (strobe.clearRun) begin
        pufChallenge <= cfgChallenge;
        onesCount    <= '0;
        zerosCount   <= '0;
        metastable   <= 1'b0;
        fracOnes     <= '0;
        biasOut      <= '0;
        noiseOut     <= '0;
      end else if (strobe.capture) begin
        if (pufResponse) onesCount  <= onesCount + CNT_W'(1);
        else             zerosCount <= zerosCount + CNT_W'(1);
        if (strobe.firstCap)              firstBit   <= pufResponse;
        else if (pufResponse != firstBit) metastable <= 1'b1;
      end
      if (strobe.divLoad) begin
        rem  <= '0;
        quot <= dividend;
      end else if (strobe.divStep) begin
        rem  <= remNext;
        quot <= {quot[DIV_W-2:0], ge};
      end
      if (strobe.storeFrac) fracOnes <= quotRes;
      if (strobe.storeBias) begin
        biasOut  <= negBias ? (~mag + BIAS_W'(1)) : mag;
        noiseOut <= noiseCalc;
      end
    end
  end

endmodule

// File: rtl/puf_stab_char.sv
module puf_stab_char
  import puf_stab_pkg::*;
#(
  parameter int CHAL_W = 64,
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     startReq,
  input  logic [CHAL_W-1:0]        cfgChallenge,
  input  logic [CNT_W-1:0]         cfgReps,
  output logic                     busy,
  output logic                     done,
  output logic [CNT_W-1:0]         onesCount,
  output logic [CNT_W-1:0]         zerosCount,
  output logic                     metastable,
  output logic [FRAC_W:0]          fracOnes,
  output logic signed [FRAC_W+1:0] biasOut,
  output logic [FRAC_W:0]          noiseOut,
  output logic [CHAL_W-1:0]        pufChallenge,
  output logic                     pufEnable,
  input  logic                     pufReady,
  input  logic                     pufResponse
);

  localparam int DIV_W = CNT_W + FRAC_W;

  ctrl_strobe_t strobe;

  puf_stab_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgReps(cfgReps),
    .pufReady(pufReady), .pufEnable(pufEnable), .busy(busy), .done(done),
    .strobe(strobe)
  );

  puf_stab_dp #(.CHAL_W(CHAL_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgChallenge(cfgChallenge),
    .pufResponse(pufResponse), .pufChallenge(pufChallenge),
    .onesCount(onesCount), .zerosCount(zerosCount), .metastable(metastable),
    .fracOnes(fracOnes), .biasOut(biasOut), .noiseOut(noiseOut)
  );

endmodule

// File: rtl/puf_stab_chk.sv
module puf_stab_chk #(
  parameter int CHAL_W = 64,
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     startReq,
  input logic [CNT_W-1:0]         cfgReps,
  input logic                     busy,
  input logic                     done,
  input logic [CNT_W-1:0]         onesCount,
  input logic [CNT_W-1:0]         zerosCount,
  input logic                     metastable,
  input logic [FRAC_W:0]          fracOnes,
  input logic signed [FRAC_W+1:0] biasOut,
  input logic [FRAC_W:0]          noiseOut,
  input logic [CHAL_W-1:0]        pufChallenge,
  input logic                     pufEnable,
  input logic                     pufReady
);

  localparam logic [FRAC_W:0] ONE_FX  = (FRAC_W+1)'(1) << FRAC_W;
  localparam logic [FRAC_W:0] HALF_FX = ONE_FX >> 1;

  logic [CNT_W:0] sumCnt;
  assign sumCnt = {1'b0, onesCount} + {1'b0, zerosCount};

  a_r1_enable_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pufEnable);

  a_r2_chal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(pufChallenge)));

  a_r3_zero_reps: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq && cfgReps == '0) |=> !busy);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pufEnable && pufReady) |=> sumCnt == $past(sumCnt) + (CNT_W+1)'(1));

  a_r5_meta_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (metastable == (onesCount != '0 && zerosCount != '0)));

  a_r6_frac_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zerosCount == '0) |-> fracOnes == ONE_FX);

  a_r7_bias_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (biasOut[FRAC_W+1] == (zerosCount > onesCount)));

  a_r8_noise_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> noiseOut <= HALF_FX);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind puf_stab_char puf_stab_chk #(.CHAL_W(CHAL_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgReps(cfgReps),
  .busy(busy), .done(done), .onesCount(onesCount), .zerosCount(zerosCount),
  .metastable(metastable), .fracOnes(fracOnes), .biasOut(biasOut),
  .noiseOut(noiseOut), .pufChallenge(pufChallenge), .pufEnable(pufEnable),
  .pufReady(pufReady)
);

// File: tb/puf_stab_char_tb.sv
module puf_stab_char_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               startReq = 1'b0;
  logic [63:0]        cfgChallenge = '0;
  logic [16:0]        cfgReps = '0;
  logic               busy, done, metastable, pufEnable;
  logic [16:0]        onesCount, zerosCount, fracOnes, noiseOut;
  logic signed [17:0] biasOut;
  logic [63:0]        pufChallenge;
  logic               pufReady, pufResponse;

  typedef struct {
    logic [63:0] chal;
    longint ones;
    longint zeros;
    bit     meta;
    longint frac;
    longint bias;
    longint noise;
  } exp_t;

  exp_t        expQ[$];
  bit          stubQ[$];
  int          checks = 0;
  int          failures = 0;
  int          stubUnder = 0;
  int          chalBad = 0;
  logic [63:0] curChal = '0;
  exp_t        lastExp;

  always #5 clk = ~clk;

  puf_stab_char u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgChallenge(cfgChallenge),
    .cfgReps(cfgReps), .busy(busy), .done(done), .onesCount(onesCount),
    .zerosCount(zerosCount), .metastable(metastable), .fracOnes(fracOnes),
    .biasOut(biasOut), .noiseOut(noiseOut), .pufChallenge(pufChallenge),
    .pufEnable(pufEnable), .pufReady(pufReady), .pufResponse(pufResponse)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural PUF core: one response per request, bits from the queue
  always @(posedge clk) begin
    if (!rst_n) begin
      pufReady    <= 1'b0;
      pufResponse <= 1'b0;
    end else if (pufReady) begin
      pufReady <= 1'b0;
    end else if (pufEnable) begin
      pufReady <= 1'b1;
      if (stubQ.size() > 0) pufResponse <= stubQ.pop_front();
      else begin
        pufResponse <= 1'b0;
        stubUnder   <= stubUnder + 1;
      end
    end
  end

  // monitor: challenge watch and result scoreboard
  always @(negedge clk) begin
    if (rst_n && pufEnable && pufChallenge != curChal) chalBad++;
    if (rst_n && done) begin
      if (expQ.size() == 0) chk("R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk("R2 challenge held", chalBad, 0);
        chk("R4 ones", onesCount, e.ones);
        chk("R4 zeros", zerosCount, e.zeros);
        chk("R5 metastable", metastable, e.meta);
        chk("R6 fraction", fracOnes, e.frac);
        chk("R7 bias", longint'(biasOut), e.bias);
        chk("R8 noise", noiseOut, e.noise);
      end
    end
  end

  task automatic runCase(input logic [63:0] chal, input int reps, input int prob,
                         input bit flipLast, input bit disturb);
    exp_t   e;
    longint ones = 0;
    longint mag;
    for (int i = 0; i < reps; i++) begin
      bit b;
      if (flipLast) b = (i != reps - 1);
      else          b = ($urandom_range(0, 999) < prob);
      stubQ.push_back(b);
      ones += b;
    end
    e.chal  = chal;
    e.ones  = ones;
    e.zeros = reps - ones;
    e.meta  = (ones != 0) && (ones != reps);
    e.frac  = (ones * 65536) / reps;
    mag     = (((ones >= e.zeros) ? ones - e.zeros : e.zeros - ones) * 65536) / reps;
    e.bias  = (ones >= e.zeros) ? mag : -mag;
    e.noise = (2 * e.frac * (65536 - e.frac)) >> 16;
    expQ.push_back(e);
    lastExp = e;
    curChal = chal;
    chalBad = 0;
    @(negedge clk);
    cfgChallenge = chal;
    cfgReps      = 17'(reps);
    startReq     = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      while (!pufReady) @(negedge clk);
      // start lands on a capture edge (R3), config changes mid-run (R2)
      startReq     = 1'b1;
      cfgChallenge = ~chal;
      cfgReps      = 17'd5;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 done single cycle", done, 0);
    chk("R9 busy falls after done", busy, 0);
    repeat (4) @(negedge clk);
    chk("R9 fraction held", fracOnes, lastExp.frac);
    chk("R9 bias held", longint'(biasOut), lastExp.bias);
    chk("R1 stub queue drained", stubQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfgChallenge = 64'hDEAD_BEEF_0123_4567;
    cfgReps      = 17'd9;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 enable", pufEnable, 0);
    chk("R10 ones", onesCount, 0);
    chk("R10 zeros", zerosCount, 0);
    chk("R10 metastable", metastable, 0);
    chk("R10 fraction", fracOnes, 0);
    chk("R10 bias", longint'(biasOut), 0);
    chk("R10 noise", noiseOut, 0);
    rst_n = 1'b1;
    @(negedge clk);

    runCase(64'h0000_0000_0000_0001, 1, 1000, 1'b0, 1'b0);    // R6 single, all ones
    runCase(64'hFFFF_0000_FFFF_0000, 200, 0, 1'b0, 1'b0);     // R7 all zeros
    runCase(64'h1234_5678_9ABC_DEF0, 1000, 500, 1'b0, 1'b0);  // R8 near half
    runCase(64'hA5A5_A5A5_5A5A_5A5A, 500, 0, 1'b1, 1'b0);     // R5 flip on last
    runCase(64'h0F0F_0F0F_0F0F_0F0F, 7, 300, 1'b0, 1'b0);
    runCase(64'hCAFE_F00D_1357_2468, 400, 500, 1'b0, 1'b1);   // R3 start mid-run
    runCase(64'h8000_0000_0000_0000, 2, 0, 1'b1, 1'b0);       // R5 two reps, one flip

    // R3 zero repetition count ignored
    @(negedge clk);
    cfgReps  = 17'd0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 zero reps busy", busy, 0);
    chk("R3 zero reps enable", pufEnable, 0);
    chk("R3 zero reps results kept", fracOnes, lastExp.frac);

    runCase(64'h0123_4567_89AB_CDEF, 2000, 900, 1'b0, 1'b0);
    chk("R1 no stub underflow", stubUnder, 0);
    chk("R9 scoreboard empty", expQ.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule